// File: doc/BRIEF.md
# Byte Field Rotate, Mask, Shift and Merge Unit

This block sits beside a byte-wide ALU and reshapes the byte being moved before it reaches its destination. Four chained stages work on the byte: a right rotator, a low-bit mask, a left shifter and a merge into a held output buffer. Which stages take part depends on where the byte comes from (a register, the I/O bus, or an immediate field) and where it goes (a register, the I/O bus, an I/O address register, or a branch/execute operand). One pass can therefore pull a bit field out of an input byte, or drop a bit field into a chosen position of the output byte, in the same cycle.

The merge result is driven on the bus output and, when the transfer is committed with `opValid`, written into the held buffer at the clock edge, so several merges in a row assemble one output byte field by field. The arithmetic and logic operations come before this block and are not part of it.

Top module: `rmsm_unit`

## Requirements
- R1: `rstN` low clears the held buffer to 0x00 at once; with a non-bus destination `busOut` then reads 0x00.
- R2: With a register source (`srcKind` 0, or the spare code 3) and a register destination (`dstKind` 0), `regOut` is `srcByte` rotated right by `rotAmt` places.
- R3: With a bus source (`srcKind` 1) and a destination of register, address register (`dstKind` 2) or operand (`dstKind` 3), `regOut` is `srcByte` rotated right by `rotAmt` and then cut to its `fieldLen` low bits; a `fieldLen` of 0 keeps all 8 bits.
- R4: With a register or immediate (`srcKind` 2) source and a bus destination (`dstKind` 1), `busOut` is the held buffer with the `fieldLen` low bits of `srcByte` inserted starting at bit `shiftAmt`; `rotAmt` has no effect, and `regOut` is 0x00 whenever the destination is the bus.
- R5: With a bus source and a bus destination, the inserted field is `srcByte` rotated right by `rotAmt` and cut to `fieldLen` bits, placed at bit `shiftAmt`.
- R6: A merge changes only the buffer bits covered by the shifted field; field bits that move above bit 7 are dropped.
- R7: When `opValid` is high and the destination is the bus, the merged byte is stored in the buffer at the rising clock edge, so consecutive merges accumulate.
- R8: When `opValid` is low the buffer keeps its value, and with a non-bus destination `busOut` shows the held buffer unchanged.
- R9: With an immediate source and a non-bus destination, `regOut` equals `srcByte`, whatever `rotAmt` and `fieldLen` are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; buffer updates on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Commits the current transfer (buffer write on bus destination) |
| srcKind | input | 2 | Source: 0 register, 1 bus, 2 immediate, 3 register |
| dstKind | input | 2 | Destination: 0 register, 1 bus, 2 address register, 3 operand |
| srcByte | input | 8 | Byte being transferred |
| rotAmt | input | 3 | Right-rotate count |
| fieldLen | input | 3 | Field length in bits, 0 meaning 8 |
| shiftAmt | input | 3 | Bit position of the inserted field |
| regOut | output | 8 | Byte for a register, address or operand destination |
| busOut | output | 8 | Merged byte for the bus, or the held buffer |

## Verification
The checker watches, on every cycle, that the held buffer does not move without a committed bus transfer, that a committed merge is what the buffer shows next, that an immediate reaches a register unchanged, that a bus destination zeroes `regOut`, and that a masked extraction never has bits above its length. The exact rotated, masked and merged values for each source and destination pairing, the dropping of bits pushed past bit 7, the accumulation of several fields into one byte and the asynchronous clear are shown only by the bench's vector table and directed sequences.

// File: rtl/rmsm_pkg.sv
package rmsm_pkg;

  typedef enum logic [1:0] {
    SRC_REG = 2'd0,
    SRC_BUS = 2'd1,
    SRC_IMM = 2'd2,
    SRC_ALT = 2'd3
  } srcKind_e;

  typedef enum logic [1:0] {
    DST_REG  = 2'd0,
    DST_BUS  = 2'd1,
    DST_ADDR = 2'd2,
    DST_OPND = 2'd3
  } dstKind_e;

  // Strobes from the control decode to the datapath stages
  typedef struct packed {
    logic rotEn;
    logic maskEn;
    logic shiftEn;
    logic mergeEn;
    logic regDrive;
    logic bufWr;
  } stageCtl_t;

endpackage

// File: rtl/rmsm_barrel.sv
// Log-depth barrel: right rotate (ROTATE=1) or left shift with zero fill (ROTATE=0)
module rmsm_barrel #(
  parameter int W      = 8,
  parameter bit ROTATE = 1'b1,
  localparam int CW    = $clog2(W)
) (
  input  logic [W-1:0]  dataIn,
  input  logic [CW-1:0] amt,
  output logic [W-1:0]  dataOut
);

  logic [W-1:0] stg [CW+1];

  assign stg[0] = dataIn;

  for (genvar k = 0; k < CW; k++) begin : g_level
    localparam int D = 1 << k;
    if (ROTATE) begin : g_rot
      assign stg[k+1] = amt[k] ? {stg[k][D-1:0], stg[k][W-1:D]} : stg[k];
    end else begin : g_shl
      assign stg[k+1] = amt[k] ? {stg[k][W-1-D:0], {D{1'b0}}} : stg[k];
    end
  end

  assign dataOut = stg[CW];

endmodule

// File: rtl/rmsm_ctrl.sv
module rmsm_ctrl
  import rmsm_pkg::*;
(
  input  logic      opValid,
  input  logic [1:0] srcKind,
  input  logic [1:0] dstKind,
  output stageCtl_t ctl
);

  logic srcIsBus;
  logic srcIsImm;
  logic dstIsBus;

  always_comb begin
    srcIsBus = (srcKind == SRC_BUS);
    srcIsImm = (srcKind == SRC_IMM);
    dstIsBus = (dstKind == DST_BUS);

    ctl = '0;
    // rotate: any bus source, or a register source heading to a non-bus target
    ctl.rotEn    = srcIsBus || (!srcIsImm && !dstIsBus);
    // mask: only bus input is cut to a field
    ctl.maskEn   = srcIsBus;
    // shift and merge: only on the way out to the bus
    ctl.shiftEn  = dstIsBus;
    ctl.mergeEn  = dstIsBus;
    ctl.regDrive = !dstIsBus;
    ctl.bufWr    = opValid && dstIsBus;
  end

endmodule

// File: rtl/rmsm_datapath.sv
module rmsm_datapath
  import rmsm_pkg::*;
#(
  parameter int           W       = 8,
  parameter logic [W-1:0] BUF_RST = '0,
  localparam int          CW      = $clog2(W)
) (
  input  logic          clk,
  input  logic          rstN,
  input  stageCtl_t     ctl,
  input  logic [W-1:0]  srcByte,
  input  logic [CW-1:0] rotAmt,
  input  logic [CW-1:0] fieldLen,
  input  logic [CW-1:0] shiftAmt,
  output logic [W-1:0]  regOut,
  output logic [W-1:0]  busOut
);

  logic [W-1:0] rotRaw;
  logic [W-1:0] rotVal;
  logic [W-1:0] lenMask;
  logic [W-1:0] mskVal;
  logic [W-1:0] shRaw;
  logic [W-1:0] shVal;
  logic [W-1:0] fieldMaskSh;
  logic [W-1:0] mergeMask;
  logic [W-1:0] merged;
  logic [W-1:0] bufQ;

  // Stage 1: rotate right
  rmsm_barrel #(.W(W), .ROTATE(1'b1)) u_rot (
    .dataIn (srcByte),
    .amt    (rotAmt),
    .dataOut(rotRaw)
  );

  assign rotVal = ctl.rotEn ? rotRaw : srcByte;

  // Stage 2: keep fieldLen low bits, zero length meaning the whole byte
  always_comb begin
    for (int i = 0; i < W; i++) begin
      lenMask[i] = (fieldLen == '0) || (CW'(i) < fieldLen);
    end
  end

  assign mskVal = ctl.maskEn ? (rotVal & lenMask) : rotVal;

  // Stage 3: shift left to the insertion point
  rmsm_barrel #(.W(W), .ROTATE(1'b0)) u_shl (
    .dataIn (mskVal),
    .amt    (shiftAmt),
    .dataOut(shRaw)
  );

  assign shVal = ctl.shiftEn ? shRaw : mskVal;

  // Field position mask follows the data through an identical shifter
  rmsm_barrel #(.W(W), .ROTATE(1'b0)) u_mshl (
    .dataIn (lenMask),
    .amt    (shiftAmt),
    .dataOut(fieldMaskSh)
  );

  // Stage 4: merge into the held buffer
  assign mergeMask = ctl.mergeEn ? fieldMaskSh : '0;
  assign merged    = (bufQ & ~mergeMask) | (shVal & mergeMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufQ <= BUF_RST;
    end else if (ctl.bufWr) begin
      bufQ <= merged;
    end
  end

  assign regOut = ctl.regDrive ? mskVal : '0;
  assign busOut = merged;

endmodule

// File: rtl/rmsm_unit.sv
module rmsm_unit
  import rmsm_pkg::*;
#(
  parameter int W  = 8,
  localparam int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          opValid,
  input  logic [1:0]    srcKind,
  input  logic [1:0]    dstKind,
  input  logic [W-1:0]  srcByte,
  input  logic [CW-1:0] rotAmt,
  input  logic [CW-1:0] fieldLen,
  input  logic [CW-1:0] shiftAmt,
  output logic [W-1:0]  regOut,
  output logic [W-1:0]  busOut
);

  stageCtl_t ctl;

  rmsm_ctrl u_ctrl (
    .opValid(opValid),
    .srcKind(srcKind),
    .dstKind(dstKind),
    .ctl    (ctl)
  );

  rmsm_datapath #(.W(W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .srcByte (srcByte),
    .rotAmt  (rotAmt),
    .fieldLen(fieldLen),
    .shiftAmt(shiftAmt),
    .regOut  (regOut),
    .busOut  (busOut)
  );

endmodule

// File: rtl/rmsm_unit_chk.sv
module rmsm_unit_chk #(
  parameter int W  = 8,
  localparam int CW = $clog2(W)
) (
  input logic          clk,
  input logic          rstN,
  input logic          opValid,
  input logic [1:0]    srcKind,
  input logic [1:0]    dstKind,
  input logic [W-1:0]  srcByte,
  input logic [CW-1:0] rotAmt,
  input logic [CW-1:0] fieldLen,
  input logic [W-1:0]  regOut,
  input logic [W-1:0]  busOut
);

  // R8: an uncommitted cycle with a non-bus target leaves the shown buffer in place
  a_r8_buf_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid && dstKind != 2'd1) |=> (dstKind == 2'd1 || $stable(busOut)));

  // R7: a committed bus merge is what the buffer shows afterwards
  a_r7_buf_write: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && dstKind == 2'd1) |=> (dstKind == 2'd1 || busOut == $past(busOut)));

  // R9: immediate to a non-bus target passes through untouched
  a_r9_imm_pass: assert property (@(posedge clk) disable iff (!rstN)
    (srcKind == 2'd2 && dstKind != 2'd1) |-> (regOut == srcByte));

  // R4: register output is idle while the bus is the destination
  a_r4_reg_idle: assert property (@(posedge clk) disable iff (!rstN)
    (dstKind == 2'd1) |-> (regOut == '0));

  // R3: an extracted field has nothing above its length
  a_r3_mask_bound: assert property (@(posedge clk) disable iff (!rstN)
    (srcKind == 2'd1 && dstKind != 2'd1 && fieldLen != '0) |-> ((regOut >> fieldLen) == '0));

  // R2: zero rotate between registers is a plain copy
  a_r2_rot_zero: assert property (@(posedge clk) disable iff (!rstN)
    (srcKind == 2'd0 && dstKind == 2'd0 && rotAmt == '0) |-> (regOut == srcByte));

endmodule

bind rmsm_unit rmsm_unit_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .opValid (opValid),
  .srcKind (srcKind),
  .dstKind (dstKind),
  .srcByte (srcByte),
  .rotAmt  (rotAmt),
  .fieldLen(fieldLen),
  .regOut  (regOut),
  .busOut  (busOut)
);

// File: tb/rmsm_unit_tb.sv
`timescale 1ns/1ps
module rmsm_unit_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [1:0] srcKind = '0;
  logic [1:0] dstKind = '0;
  logic [7:0] srcByte = '0;
  logic [2:0] rotAmt = '0;
  logic [2:0] fieldLen = '0;
  logic [2:0] shiftAmt = '0;
  logic [7:0] regOut;
  logic [7:0] busOut;

  int total = 0;
  int failed = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rmsm_unit u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid),
    .srcKind(srcKind), .dstKind(dstKind), .srcByte(srcByte),
    .rotAmt(rotAmt), .fieldLen(fieldLen), .shiftAmt(shiftAmt),
    .regOut(regOut), .busOut(busOut)
  );

  // {srcKind, dstKind, srcByte, rotAmt, fieldLen, shiftAmt, expReg, expBus, reqNum}
  localparam int NV = 10;
  localparam logic [40:0] VEC [NV] = '{
    {2'd0, 2'd0, 8'hA5, 3'd1, 3'd0, 3'd0, 8'hD2, 8'h00, 4'd2}, // R2
    {2'd0, 2'd0, 8'h81, 3'd4, 3'd0, 3'd0, 8'h18, 8'h00, 4'd2}, // R2
    {2'd1, 2'd0, 8'hB6, 3'd2, 3'd3, 3'd0, 8'h05, 8'h00, 4'd3}, // R3
    {2'd1, 2'd2, 8'hF0, 3'd4, 3'd0, 3'd0, 8'h0F, 8'h00, 4'd3}, // R3 full length
    {2'd1, 2'd3, 8'h3C, 3'd0, 3'd4, 3'd0, 8'h0C, 8'h00, 4'd3}, // R3
    {2'd0, 2'd1, 8'h0B, 3'd5, 3'd3, 3'd4, 8'h00, 8'h30, 4'd4}, // R4
    {2'd2, 2'd1, 8'hFF, 3'd0, 3'd2, 3'd7, 8'h00, 8'h80, 4'd6}, // R6 top bit dropped
    {2'd1, 2'd1, 8'h96, 3'd4, 3'd4, 3'd2, 8'h00, 8'h24, 4'd5}, // R5
    {2'd2, 2'd0, 8'h5A, 3'd3, 3'd5, 3'd0, 8'h5A, 8'h00, 4'd9}, // R9
    {2'd2, 2'd2, 8'h77, 3'd6, 3'd1, 3'd0, 8'h77, 8'h00, 4'd9}  // R9
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] sk, input logic [1:0] dk, input logic [7:0] b,
                       input logic [2:0] r, input logic [2:0] l, input logic [2:0] s,
                       input logic v);
    @(negedge clk);
    srcKind = sk; dstKind = dk; srcByte = b;
    rotAmt = r; fieldLen = l; shiftAmt = s; opValid = v;
    #2;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog: actual hung expected done");
      finishRun();
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    #2;
    check("R1 reset buffer", busOut, 8'h00);
    @(negedge clk);
    rstN = 1'b1;

    // table walk, no commits, buffer stays 0x00
    for (int i = 0; i < NV; i++) begin
      logic [40:0] v;
      string tag;
      v = VEC[i];
      drive(v[40:39], v[38:37], v[36:29], v[28:26], v[25:23], v[22:20], 1'b0);
      tag = $sformatf("R%0d vec%0d", v[3:0], i);
      check({tag, " regOut"}, regOut, v[19:12]);
      check({tag, " busOut"}, busOut, v[11:4]);
    end

    // R4: full byte at bit 0, committed
    drive(2'd0, 2'd1, 8'hAB, 3'd3, 3'd0, 3'd0, 1'b1);
    check("R4 full merge", busOut, 8'hAB);
    // R7: stored value visible with a register target
    drive(2'd0, 2'd0, 8'h00, 3'd0, 3'd0, 3'd0, 1'b0);
    check("R7 stored", busOut, 8'hAB);
    // R6: low nibble replaced, high nibble kept
    drive(2'd0, 2'd1, 8'h05, 3'd0, 3'd4, 3'd0, 1'b1);
    check("R6 partial merge", busOut, 8'hA5);
    // R7: accumulate a 2-bit field at bit 6
    drive(2'd2, 2'd1, 8'h03, 3'd0, 3'd2, 3'd6, 1'b1);
    check("R7 accumulate", busOut, 8'hE5);
    // R5: bus to bus full byte, not committed
    drive(2'd1, 2'd1, 8'h12, 3'd0, 3'd0, 3'd0, 1'b0);
    check("R5 bus to bus", busOut, 8'h12);
    // R8: uncommitted transfer left the buffer alone
    drive(2'd0, 2'd0, 8'h00, 3'd0, 3'd0, 3'd0, 1'b0);
    check("R8 hold", busOut, 8'hE5);
    check("R2 zero rotate", regOut, 8'h00);
    // R6: bits past bit 7 dropped, low nibble kept
    drive(2'd0, 2'd1, 8'hFF, 3'd0, 3'd0, 3'd4, 1'b0);
    check("R6 overflow drop", busOut, 8'hF5);
    // R2: spare source code behaves as register
    drive(2'd3, 2'd0, 8'h01, 3'd1, 3'd0, 3'd0, 1'b0);
    check("R2 spare code", regOut, 8'h80);
    // R1: asynchronous clear mid-run
    @(negedge clk);
    dstKind = 2'd0; opValid = 1'b0;
    rstN = 1'b0;
    #2;
    check("R1 async clear", busOut, 8'h00);
    @(negedge clk);
    rstN = 1'b1;

    done = 1'b1;
    finishRun();
  end

endmodule